// File: doc/BRIEF.md
# Burst DMA Transfer Sequencer

This block is one DMA channel that copies a block of data in a single burst. Each unit moves a byte or a word. The block reads the unit from a source address and then writes it to a destination address. Software loads the addresses, a unit count, the unit size, the per-address stepping controls and the end-marker enable while the channel is idle. It then sets the channel enable. A start request begins the burst.

Once the burst has begun, the channel holds the bus until the count is used up. One idle state follows the last write, and only then does the channel release the bus. A requester of higher priority gets the bus only while the channel is idle. A non-maskable event clears the enable and ends the burst at the next unit boundary. The count and the addresses are kept, so the burst can be resumed later. The one exception is the final unit: if it has already begun, it runs to completion together with its idle state.

Top module: `burstDma`

## Requirements
- R1: After an accepted start, `busOwn` stays high with no gap until the burst ends. A burst of N units ending at count zero holds the bus for exactly 4N+1 clocks.
- R2: Each unit is a read of the source address (`busRd` high, `busAddr` = source) followed by a write to the destination address (`busAddr` = destination). A read and a write strobe are never high together.
- R3: Every read access and every write access lasts exactly two consecutive clocks.
- R4: After the write of the unit that brings the count to zero, there is one clock with `busOwn` high and no strobe. `busOwn` falls after that clock.
- R5: `hiPriGrant` equals `hiPriReq` while the channel is idle and is 0 while `busOwn` is high. A start request is not accepted while `hiPriReq` is high.
- R6: When `nmi` is high at a clock edge, `chanEn` is 0 after that edge. `nmi` takes priority over `enSet`.
- R7: If `nmi` arrives during a unit that is not the final one, that unit completes and the bus is released with no idle state. `xferCnt`, `srcAddr` and `dstAddr` then show the values after that unit.
- R8: If `nmi` arrives during the final unit, that unit completes, the idle state follows, and `xferCnt` reaches 0.
- R9: `tendN` is low during the four access clocks of the final unit (count equal to 1) when `cfgTendEn` was loaded as 1. It is high at all other times.
- R10: After each unit, each address with its step control set advances by 2 in word mode and by 1 in byte mode. Each address with its step control clear stays unchanged. `xferCnt` decreases by 1.
- R11: A word write drives both `busWrHi` and `busWrLo` with the read word. A byte write drives `busWrHi` when destination bit 0 is 0 and `busWrLo` when it is 1. The byte comes from `busRdata[15:8]` when source bit 0 is 0 and from `[7:0]` when it is 1, and it is copied onto both halves of `busWdata`.
- R12: After a suspension, setting `enSet` and then giving a start request continues the burst from the saved addresses and count.
- R13: A start request is ignored while `chanEn` is 0 or `xferCnt` is 0. `busOwn` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgLoad | input | 1 | Load the configuration inputs (accepted only when idle) |
| cfgSrc | input | ADDR_W | Source start address |
| cfgDst | input | ADDR_W | Destination start address |
| cfgCnt | input | CNT_W | Number of units |
| cfgWord | input | 1 | 1 = word units, 0 = byte units |
| cfgSrcInc | input | 1 | Step the source address after each unit |
| cfgDstInc | input | 1 | Step the destination address after each unit |
| cfgTendEn | input | 1 | Enable the end marker on `tendN` |
| enSet | input | 1 | Set the channel enable |
| startReq | input | 1 | Start request |
| nmi | input | 1 | Non-maskable event; clears the enable |
| hiPriReq | input | 1 | Bus request from a higher-priority requester |
| busRdata | input | 16 | Read data |
| busAddr | output | ADDR_W | Bus address |
| busRd | output | 1 | Read strobe |
| busWrHi | output | 1 | Write strobe for the upper byte |
| busWrLo | output | 1 | Write strobe for the lower byte |
| busWdata | output | 16 | Write data |
| busWord | output | 1 | Access size (1 = word) |
| busOwn | output | 1 | Channel holds the bus |
| hiPriGrant | output | 1 | Bus granted to the higher-priority requester |
| tendN | output | 1 | Active-low end marker for the final unit |
| chanEn | output | 1 | Channel enable |
| srcAddr | output | ADDR_W | Current source address |
| dstAddr | output | ADDR_W | Current destination address |
| xferCnt | output | CNT_W | Remaining unit count |

## Verification
The bench aims `nmi` at a middle unit and at the final unit. A design that releases the bus mid-unit, adds the idle state to a suspended burst, or drops the idle state from a final unit cut short shows a different sequence of bus cycles. It also raises `hiPriReq` during a burst and before a start. A grant that appears in the middle of a burst, or a start that overrides the other requester, is reported. Byte runs use odd and even source and destination addresses with stepping on and off, which exposes a wrong lane choice, a wrong step size or an address that steps when it should not. The end marker is checked cycle by cycle, so a marker that covers the wrong unit or the idle state is caught.

// File: rtl/burstDmaPkg.sv
package burstDmaPkg;
  localparam int DATA_W = 16;
  localparam int LANES = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_WR1,
    ST_WR2,
    ST_DEAD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic rdPhase;
    logic capRd;
    logic wrPhase;
    logic stepUnit;
  } pathStrb_t;
endpackage

// File: rtl/burstDmaPath.sv
module burstDmaPath
  import burstDmaPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrb_t         strb,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgCnt,
  input  logic              cfgWord,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic              cfgTendEn,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWrHi,
  output logic              busWrLo,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWord,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  xferCnt,
  output logic              lastUnit,
  output logic              cntZero,
  output logic              tendEnable
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              wordMode, srcStep, dstStep;
  logic [DATA_W-1:0] dataReg;
  logic [ADDR_W-1:0] stepAmt;
  logic [7:0]        srcByte;
  logic [LANES-1:0]  laneSel;

  assign stepAmt = wordMode ? ADDR_W'(2) : ADDR_W'(1);
  assign srcByte = srcAddr[0] ? busRdata[7:0] : busRdata[15:8];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr    <= '0;
      dstAddr    <= '0;
      xferCnt    <= '0;
      wordMode   <= 1'b0;
      srcStep    <= 1'b0;
      dstStep    <= 1'b0;
      tendEnable <= 1'b0;
      dataReg    <= '0;
    end else begin
      if (strb.loadCfg) begin
        srcAddr    <= cfgSrc;
        dstAddr    <= cfgDst;
        xferCnt    <= cfgCnt;
        wordMode   <= cfgWord;
        srcStep    <= cfgSrcInc;
        dstStep    <= cfgDstInc;
        tendEnable <= cfgTendEn;
      end else if (strb.stepUnit) begin
        if (srcStep) srcAddr <= srcAddr + stepAmt;
        if (dstStep) dstAddr <= dstAddr + stepAmt;
        xferCnt <= xferCnt - CNT_ONE;
      end
      if (strb.capRd)
        dataReg <= wordMode ? busRdata : {srcByte, srcByte};
    end
  end

  // lane 1 is the upper byte (even address), lane 0 the lower (odd)
  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    assign laneSel[ln] = wordMode | (dstAddr[0] == ((ln == 0) ? 1'b1 : 1'b0));
  end

  assign busAddr  = strb.wrPhase ? dstAddr : srcAddr;
  assign busRd    = strb.rdPhase;
  assign busWrHi  = strb.wrPhase & laneSel[1];
  assign busWrLo  = strb.wrPhase & laneSel[0];
  assign busWdata = dataReg;
  assign busWord  = wordMode;
  assign lastUnit = (xferCnt == CNT_ONE);
  assign cntZero  = (xferCnt == '0);
endmodule

// File: rtl/burstDmaCtrl.sv
module burstDmaCtrl
  import burstDmaPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgLoad,
  input  logic      enSet,
  input  logic      startReq,
  input  logic      nmi,
  input  logic      hiPriReq,
  input  logic      lastUnit,
  input  logic      cntZero,
  input  logic      tendEnable,
  output pathStrb_t strb,
  output logic      busOwn,
  output logic      tendN,
  output logic      hiPriGrant,
  output logic      chanEn
);
  seqState_t state, stateNxt;
  logic      inAccess;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (chanEn && startReq && !hiPriReq && !cntZero) stateNxt = ST_RD1;
      ST_RD1:  stateNxt = ST_RD2;
      ST_RD2:  stateNxt = ST_WR1;
      ST_WR1:  stateNxt = ST_WR2;
      ST_WR2: begin
        if (lastUnit)             stateNxt = ST_DEAD;
        else if (chanEn && !nmi)  stateNxt = ST_RD1;
        else                      stateNxt = ST_IDLE;
      end
      ST_DEAD: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      chanEn <= 1'b0;
    end else begin
      state <= stateNxt;
      if (nmi)        chanEn <= 1'b0;
      else if (enSet) chanEn <= 1'b1;
    end
  end

  assign inAccess      = (state == ST_RD1) || (state == ST_RD2) ||
                         (state == ST_WR1) || (state == ST_WR2);
  assign strb.loadCfg  = cfgLoad && (state == ST_IDLE);
  assign strb.rdPhase  = (state == ST_RD1) || (state == ST_RD2);
  assign strb.capRd    = (state == ST_RD2);
  assign strb.wrPhase  = (state == ST_WR1) || (state == ST_WR2);
  assign strb.stepUnit = (state == ST_WR2);
  assign busOwn        = (state != ST_IDLE);
  assign tendN         = !(inAccess && lastUnit && tendEnable);
  assign hiPriGrant    = hiPriReq && (state == ST_IDLE);
endmodule

// File: rtl/burstDma.sv
module burstDma
  import burstDmaPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgCnt,
  input  logic              cfgWord,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic              cfgTendEn,
  input  logic              enSet,
  input  logic              startReq,
  input  logic              nmi,
  input  logic              hiPriReq,
  input  logic [15:0]       busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWrHi,
  output logic              busWrLo,
  output logic [15:0]       busWdata,
  output logic              busWord,
  output logic              busOwn,
  output logic              hiPriGrant,
  output logic              tendN,
  output logic              chanEn,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  xferCnt
);
  pathStrb_t strb;
  logic      lastUnit, cntZero, tendEnable;

  burstDmaCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .enSet(enSet),
    .startReq(startReq), .nmi(nmi), .hiPriReq(hiPriReq),
    .lastUnit(lastUnit), .cntZero(cntZero), .tendEnable(tendEnable),
    .strb(strb), .busOwn(busOwn), .tendN(tendN),
    .hiPriGrant(hiPriGrant), .chanEn(chanEn)
  );

  burstDmaPath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgSrc(cfgSrc), .cfgDst(cfgDst), .cfgCnt(cfgCnt), .cfgWord(cfgWord),
    .cfgSrcInc(cfgSrcInc), .cfgDstInc(cfgDstInc), .cfgTendEn(cfgTendEn),
    .busRdata(busRdata), .busAddr(busAddr), .busRd(busRd),
    .busWrHi(busWrHi), .busWrLo(busWrLo), .busWdata(busWdata),
    .busWord(busWord), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .xferCnt(xferCnt), .lastUnit(lastUnit), .cntZero(cntZero),
    .tendEnable(tendEnable)
  );
endmodule

// File: rtl/burstDmaChk.sv
module burstDmaChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busRd,
  input logic             busWrHi,
  input logic             busWrLo,
  input logic             busOwn,
  input logic             hiPriGrant,
  input logic             tendN,
  input logic             chanEn,
  input logic             nmi,
  input logic [CNT_W-1:0] xferCnt
);
  logic anyWr;
  assign anyWr = busWrHi | busWrLo;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && anyWr)); // R2
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || anyWr) |-> busOwn); // R1
  AST_READ_TWO_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRd) |=> busRd); // R3
  AST_WRITE_TWO_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyWr) |=> anyWr); // R3
  AST_DEAD_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busOwn) && xferCnt == '0) |-> $past(busOwn && !busRd && !anyWr)); // R4
  AST_GRANT_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    hiPriGrant |-> !busOwn); // R5
  AST_NMI_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
    nmi |=> !chanEn); // R6
  AST_TEND_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !tendN |-> (busRd || anyWr)); // R9
endmodule

bind burstDma burstDmaChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busWrHi(busWrHi),
  .busWrLo(busWrLo), .busOwn(busOwn), .hiPriGrant(hiPriGrant),
  .tendN(tendN), .chanEn(chanEn), .nmi(nmi), .xferCnt(xferCnt)
);

// File: tb/burstDma_test.sv
`timescale 1ns/1ps
module burstDma_test;
  localparam int AW = 24;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgLoad = 1'b0, cfgWord = 1'b0, cfgSrcInc = 1'b0, cfgDstInc = 1'b0, cfgTendEn = 1'b0;
  logic [AW-1:0] cfgSrc = '0, cfgDst = '0;
  logic [CW-1:0] cfgCnt = '0;
  logic          enSet = 1'b0, startReq = 1'b0, nmi = 1'b0, hiPriReq = 1'b0;
  logic [15:0]   busRdata;
  logic [AW-1:0] busAddr, srcAddr, dstAddr;
  logic          busRd, busWrHi, busWrLo, busWord, busOwn, hiPriGrant, tendN, chanEn;
  logic [15:0]   busWdata;
  logic [CW-1:0] xferCnt;

  always #5 clk = ~clk;

  burstDma #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSrc(cfgSrc), .cfgDst(cfgDst),
    .cfgCnt(cfgCnt), .cfgWord(cfgWord), .cfgSrcInc(cfgSrcInc), .cfgDstInc(cfgDstInc),
    .cfgTendEn(cfgTendEn), .enSet(enSet), .startReq(startReq), .nmi(nmi),
    .hiPriReq(hiPriReq), .busRdata(busRdata), .busAddr(busAddr), .busRd(busRd),
    .busWrHi(busWrHi), .busWrLo(busWrLo), .busWdata(busWdata), .busWord(busWord),
    .busOwn(busOwn), .hiPriGrant(hiPriGrant), .tendN(tendN), .chanEn(chanEn),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .xferCnt(xferCnt)
  );

  function automatic logic [15:0] memVal(logic [AW-1:0] a);
    return {~a[7:0], a[7:0] ^ 8'h5A};
  endfunction
  assign busRdata = memVal(busAddr);

  typedef struct {
    logic          rd, wrHi, wrLo, tn, cmpAddr, cmpData;
    logic [AW-1:0] addr;
    logic [15:0]   data;
    string         req;
  } busItem_t;

  busItem_t expQ[$];
  int nChecks = 0, nFails = 0, ownCycles = 0;

  // bench-side model of the channel registers
  logic [AW-1:0] mSrc, mDst;
  logic [CW-1:0] mCnt;
  logic          mWord, mSi, mDi, mTe;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushItem(logic rd, logic hi, logic lo, logic tn, logic ca, logic cd,
                          logic [AW-1:0] a, logic [15:0] d, string req);
    busItem_t it;
    it.rd = rd; it.wrHi = hi; it.wrLo = lo; it.tn = tn; it.cmpAddr = ca;
    it.cmpData = cd; it.addr = a; it.data = d; it.req = req;
    expQ.push_back(it);
  endtask

  // driver side: expected bus cycles for n units
  task automatic pushUnits(int n);
    for (int u = 0; u < n; u++) begin
      logic        last, tn;
      logic [15:0] rv, dv;
      logic [7:0]  b;
      last = (mCnt == 1);
      tn   = !(mTe && last);
      rv   = memVal(mSrc);
      b    = mSrc[0] ? rv[7:0] : rv[15:8];
      dv   = mWord ? rv : {b, b};
      for (int k = 0; k < 2; k++)
        pushItem(1'b1, 1'b0, 1'b0, tn, 1'b1, 1'b0, mSrc, '0, last ? "R9" : "R2");
      for (int k = 0; k < 2; k++)
        pushItem(1'b0, mWord | !mDst[0], mWord | mDst[0], tn, 1'b1, 1'b1, mDst, dv, "R11");
      if (mSi) mSrc = mSrc + (mWord ? 2 : 1);
      if (mDi) mDst = mDst + (mWord ? 2 : 1);
      mCnt = mCnt - 1;
      if (mCnt == 0) pushItem(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R4");
    end
  endtask

  // monitor: compare each bus cycle with the queue
  always @(negedge clk) begin
    if (rstN) begin
      if (busOwn) begin
        ownCycles++;
        if (expQ.size() == 0) begin
          chk("R1", {busRd, busWrHi, busWrLo}, 32'hFFFF);
        end else begin
          busItem_t it;
          it = expQ.pop_front();
          chk(it.req, {busRd, busWrHi, busWrLo, tendN}, {it.rd, it.wrHi, it.wrLo, it.tn});
          if (it.cmpAddr) chk(it.req, busAddr, it.addr);
          if (it.cmpData) chk(it.req, busWdata, it.data);
        end
      end else begin
        chk("R2", {busRd, busWrHi, busWrLo, tendN}, 4'b0001);
      end
    end
  end

  task automatic loadCfg(logic [AW-1:0] s, logic [AW-1:0] d, logic [CW-1:0] c,
                         logic w, logic si, logic di, logic te);
    @(posedge clk); #1;
    cfgSrc = s; cfgDst = d; cfgCnt = c; cfgWord = w;
    cfgSrcInc = si; cfgDstInc = di; cfgTendEn = te; cfgLoad = 1'b1;
    @(posedge clk); #1 cfgLoad = 1'b0;
    mSrc = s; mDst = d; mCnt = c; mWord = w; mSi = si; mDi = di; mTe = te;
  endtask

  task automatic pulseEn();
    @(posedge clk); #1 enSet = 1'b1;
    @(posedge clk); #1 enSet = 1'b0;
  endtask

  task automatic runBurst(int nmiAt);
    ownCycles = 0;
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    if (nmiAt >= 0) begin
      repeat (nmiAt) @(posedge clk);
      #1 nmi = 1'b1;
      @(posedge clk); #1 nmi = 1'b0;
    end
    do @(negedge clk); while (busOwn);
    chk("R1", expQ.size(), 0);
  endtask

  task automatic startIgnored(string req);
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(req, busOwn, 1'b0);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1", busOwn, 1'b0);
    chk("R9", tendN, 1'b1);
    chk("R6", chanEn, 1'b0);

    // word burst, both addresses step, end marker on
    loadCfg(24'h000100, 24'h000200, 3, 1'b1, 1'b1, 1'b1, 1'b1);
    pulseEn();
    pushUnits(3);
    runBurst(-1);
    chk("R1", ownCycles, 13);
    chk("R10", srcAddr, 24'h000106);
    chk("R10", dstAddr, 24'h000206);
    chk("R10", xferCnt, 0);
    startIgnored("R13");

    // byte burst, odd source stepping, fixed even destination
    loadCfg(24'h000301, 24'h000410, 3, 1'b0, 1'b1, 1'b0, 1'b0);
    pushUnits(3);
    runBurst(-1);
    chk("R10", srcAddr, 24'h000304);
    chk("R10", dstAddr, 24'h000410);

    // byte burst, fixed even source, odd destination stepping
    loadCfg(24'h000500, 24'h000601, 2, 1'b0, 1'b0, 1'b1, 1'b1);
    pushUnits(2);
    runBurst(-1);
    chk("R10", dstAddr, 24'h000603);

    // higher-priority requester while idle, then during a burst
    loadCfg(24'h000A00, 24'h000B00, 2, 1'b1, 1'b1, 1'b1, 1'b0);
    @(posedge clk); #1 hiPriReq = 1'b1;
    startIgnored("R5");
    chk("R5", hiPriGrant, 1'b1);
    @(posedge clk); #1 hiPriReq = 1'b0;
    pushUnits(2);
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0; hiPriReq = 1'b1;
    @(negedge clk);
    chk("R5", {busOwn, hiPriGrant}, 2'b10);
    do @(negedge clk); while (busOwn);
    chk("R5", hiPriGrant, 1'b1);
    chk("R1", expQ.size(), 0);
    @(posedge clk); #1 hiPriReq = 1'b0;

    // NMI during second of four units: suspend after it
    loadCfg(24'h000700, 24'h000800, 4, 1'b1, 1'b1, 1'b1, 1'b1);
    pushUnits(2);
    runBurst(5);
    chk("R7", ownCycles, 8);
    chk("R6", chanEn, 1'b0);
    chk("R7", xferCnt, 2);
    chk("R7", srcAddr, 24'h000704);
    chk("R7", dstAddr, 24'h000804);
    startIgnored("R13");
    pulseEn();
    pushUnits(2);
    runBurst(-1);
    chk("R12", xferCnt, 0);
    chk("R12", srcAddr, 24'h000708);
    chk("R12", ownCycles, 9);

    // NMI during the final unit: runs to the end with the idle state
    loadCfg(24'h000900, 24'h000C00, 1, 1'b0, 1'b1, 1'b1, 1'b1);
    pulseEn();
    pushUnits(1);
    runBurst(0);
    chk("R8", ownCycles, 5);
    chk("R8", xferCnt, 0);
    chk("R6", chanEn, 1'b0);

    repeat (2) @(posedge clk);
    summary();
  end
endmodule